// File: doc/BRIEF.md
# Group Blink Generator with Multi-Chip Phase Sync

This block produces one shared blink gate for an LED driver. A slow base tick is divided by a programmable frequency code into 256 phase steps per blink period, and the gate is high while the phase is below a programmable duty code. Each output channel can either pass its PWM unchanged or have it masked by the shared gate. The PWM generator and the register interface sit outside this block. The block takes the already-committed frequency and duty codes as inputs.

Several chips can share one blink phase over a single clock pin. A two-bit mode field selects the role. In master mode the block drives a square wave at the blink rate on that pin. In slave mode it treats the pin as an input and restarts its phase on each rising edge. In the two remaining codes the pin is not driven and is held low. New frequency and duty codes are picked up only at a period boundary, so a blink cycle already in progress is never cut short.

Top module: `blink_sync_gen`

## Requirements
- R1: While reset is asserted and right after it, blinkOn, clkOut and clkOutEn are 0 and the active duty is 0, so gateOut equals the inverse of chanEnable.
- R2: With baseTick high on every cycle and frequency code F, one blink period lasts 256*(F+1) clock cycles.
- R3: blinkOn is high for the first D*(F+1) base ticks of each period, where D is the duty code. D=0 keeps it low for the whole period and D=255 leaves only the last F+1 ticks low.
- R4: With syncMode=2'b10 (master), clkOutEn is 1 and clkOut is high for the second half of every period, 128*(F+1) base ticks. clkOut falls exactly when a new period starts.
- R5: With syncMode=2'b00 or 2'b01, clkOut and clkOutEn are both 0.
- R6: With syncMode=2'b11 (slave), clkOut and clkOutEn are 0. A rising edge on clkIn restarts the phase at zero on the third rising clock edge after clkIn goes high. If D>0, blinkOn is then high for D*(F+1) base ticks.
- R7: Changes to freqCode and dutyCode take effect only at a period boundary (phase wrap or slave restart). The period in progress keeps its old length.
- R8: For each channel i, gateOut[i] is 1 when chanEnable[i] is 0 and equals blinkOn when chanEnable[i] is 1.
- R9: The phase advances only on cycles where baseTick is high. A base tick asserted every other cycle doubles the period in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | Base time tick strobe |
| freqCode | input | 8 | Committed blink frequency code F |
| dutyCode | input | 8 | Committed blink duty code D |
| syncMode | input | 2 | 00/01 none, 10 master, 11 slave |
| chanEnable | input | 18 | Per-channel blink enable (1 = gated) |
| clkIn | input | 1 | Sync clock from the shared pin (asynchronous) |
| blinkOn | output | 1 | Shared blink gate |
| clkOut | output | 1 | Sync clock driven onto the shared pin |
| clkOutEn | output | 1 | Output enable for the shared pin |
| gateOut | output | 18 | Per-channel PWM pass mask |

## Verification
The bench measures whole periods between falling edges of the master clock. It checks the period length, the on-time and the clock high time for duty codes 0, 1, 0x40, 0x80, 0xC0 and 0xFF across several frequency codes. Any off-by-one in the prescaler or in the duty compare shows up as a count that is wrong by F+1. A code change written just after a boundary must leave that period at its old length, so a design that loads codes at once would produce a short or long period. A half-rate base tick exposes a divider that counts clock cycles instead of ticks. The slave test raises clkIn just after the gate has closed. A wrong synchronizer depth moves the restart by a cycle, and a restart that does not reload the codes gives the wrong on-time.

// File: rtl/blink_pkg.sv
package blink_pkg;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'b00,
    MODE_NONE_B = 2'b01,
    MODE_MASTER = 2'b10,
    MODE_SLAVE  = 2'b11
  } syncMode_e;

  typedef struct packed {
    logic step;     // advance phase by one
    logic restart;  // slave sync edge: phase back to zero
    logic load;     // period boundary: commit new codes
  } blinkStrb_t;

endpackage

// File: rtl/blink_ctrl.sv
module blink_ctrl
  import blink_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baseTick,
  input  logic [1:0]        syncMode,
  input  logic              clkIn,
  input  logic [CODE_W-1:0] freqAct,
  input  logic              phaseLast,
  output blinkStrb_t        strb,
  output logic              isMaster
);

  localparam int SMSB = SYNC_STAGES - 1;

  syncMode_e        modeSel;
  logic             isSlave;
  logic [SMSB:0]    syncPipe;
  logic             syncPrev;
  logic             syncRise;
  logic [CODE_W-1:0] subCnt;
  logic             subDone;

  assign modeSel  = syncMode_e'(syncMode);
  assign isMaster = (modeSel == MODE_MASTER);
  assign isSlave  = (modeSel == MODE_SLAVE);

  // input synchronizer and edge detector for the shared clock pin
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncPipe <= '0;
      syncPrev <= 1'b0;
    end else begin
      syncPipe <= {syncPipe[SMSB-1:0], clkIn};
      syncPrev <= syncPipe[SMSB];
    end
  end

  assign syncRise = syncPipe[SMSB] & ~syncPrev;

  // prescaler: each phase step lasts freqAct+1 base ticks
  assign subDone = (subCnt == freqAct);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      subCnt <= '0;
    end else if (strb.restart) begin
      subCnt <= '0;
    end else if (baseTick) begin
      subCnt <= subDone ? '0 : subCnt + 1'b1;
    end
  end

  always_comb begin
    strb.restart = isSlave & syncRise;
    strb.step    = baseTick & subDone & ~strb.restart;
    strb.load    = strb.restart | (strb.step & phaseLast);
  end

  // R2: prescaler never runs past the active frequency code
  a_r2_sub_bound: assert property (@(posedge clk) disable iff (!rst_n)
    subCnt <= freqAct);

endmodule

// File: rtl/blink_dp.sv
module blink_dp
  import blink_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  blinkStrb_t        strb,
  input  logic [CODE_W-1:0] freqCode,
  input  logic [CODE_W-1:0] dutyCode,
  input  logic              isMaster,
  output logic [CODE_W-1:0] freqAct,
  output logic              phaseLast,
  output logic              blinkOn,
  output logic              clkOut,
  output logic              clkOutEn
);

  localparam logic [CODE_W-1:0] PHASE_MAX = '1;

  logic [CODE_W-1:0] phaseCnt;
  logic [CODE_W-1:0] dutyAct;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phaseCnt <= '0;
    end else if (strb.restart) begin
      phaseCnt <= '0;
    end else if (strb.step) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freqAct <= '0;
      dutyAct <= '0;
    end else if (strb.load) begin
      freqAct <= freqCode;
      dutyAct <= dutyCode;
    end
  end

  assign phaseLast = (phaseCnt == PHASE_MAX);
  assign blinkOn   = (phaseCnt < dutyAct);
  assign clkOutEn  = isMaster;
  assign clkOut    = isMaster & phaseCnt[CODE_W-1];

  // R7: committed codes only move on a boundary strobe
  a_r7_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> ($stable(freqAct) && $stable(dutyAct)));

  // R9: phase is frozen without a step or restart
  a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.step && !strb.restart) |=> $stable(phaseCnt));

  // R6: slave restart lands on phase zero
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strb.restart |=> (phaseCnt == '0));

  // R2: a step from the last phase wraps to zero
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && phaseLast && !strb.restart) |=> (phaseCnt == '0));

  // R3: zero duty never opens the gate
  a_r3_duty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dutyAct == '0) |-> !blinkOn);

endmodule

// File: rtl/blink_sync_gen.sv
module blink_sync_gen
  import blink_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int NUM_CH      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baseTick,
  input  logic [CODE_W-1:0] freqCode,
  input  logic [CODE_W-1:0] dutyCode,
  input  logic [1:0]        syncMode,
  input  logic [NUM_CH-1:0] chanEnable,
  input  logic              clkIn,
  output logic              blinkOn,
  output logic              clkOut,
  output logic              clkOutEn,
  output logic [NUM_CH-1:0] gateOut
);

  blinkStrb_t        strb;
  logic              isMaster;
  logic [CODE_W-1:0] freqAct;
  logic              phaseLast;

  blink_ctrl #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .baseTick(baseTick), .syncMode(syncMode),
    .clkIn(clkIn), .freqAct(freqAct), .phaseLast(phaseLast),
    .strb(strb), .isMaster(isMaster)
  );

  blink_dp #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .freqCode(freqCode),
    .dutyCode(dutyCode), .isMaster(isMaster), .freqAct(freqAct),
    .phaseLast(phaseLast), .blinkOn(blinkOn), .clkOut(clkOut),
    .clkOutEn(clkOutEn)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_gate
    assign gateOut[i] = ~chanEnable[i] | blinkOn;
  end

  // R8: a channel without blink enable is always passed
  a_r8_pass_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (gateOut | chanEnable) == '1);

  // R5: no sync role means the pin is neither driven nor high
  a_r5_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !syncMode[1] |-> (!clkOutEn && !clkOut));

endmodule

// File: tb/sim_blink_sync_gen.sv
module sim_blink_sync_gen;

  localparam int NCH = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baseTick = 1'b1;
  logic halfRate = 1'b0;
  logic [7:0] freqCode = '0;
  logic [7:0] dutyCode = '0;
  logic [1:0] syncMode = 2'b00;
  logic [NCH-1:0] chanEnable = 18'h2AAAA;
  logic clkIn = 1'b0;
  logic blinkOn, clkOut, clkOutEn;
  logic [NCH-1:0] gateOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) baseTick <= halfRate ? ~baseTick : 1'b1;

  blink_sync_gen u0 (
    .clk(clk), .rst_n(rst_n), .baseTick(baseTick), .freqCode(freqCode),
    .dutyCode(dutyCode), .syncMode(syncMode), .chanEnable(chanEnable),
    .clkIn(clkIn), .blinkOn(blinkOn), .clkOut(clkOut), .clkOutEn(clkOutEn),
    .gateOut(gateOut)
  );

  // {freq, duty}
  localparam logic [15:0] VEC [6] = '{
    {8'd0, 8'h80}, {8'd0, 8'h00}, {8'd0, 8'hFF},
    {8'd1, 8'h40}, {8'd2, 8'h01}, {8'd3, 8'hC0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic findFall(output bit found);
    logic prev;
    prev = clkOut;
    found = 1'b0;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (prev && !clkOut) begin
        found = 1'b1;
        return;
      end
      prev = clkOut;
    end
  endtask

  // call at the negedge where clkOut has just fallen
  task automatic measure(output int per, output int on, output int hi);
    logic prev;
    per = 1; on = int'(blinkOn); hi = int'(clkOut);
    prev = clkOut;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (prev && !clkOut) return;
      per++; on += int'(blinkOn); hi += int'(clkOut);
      prev = clkOut;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit found;
    int per, on, hi, f, d;

    repeat (4) @(negedge clk);
    // R1: outputs during reset
    check(!blinkOn && !clkOut && !clkOutEn, "R1 reset outputs", int'(blinkOn), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(gateOut == ~chanEnable, "R1 gate after reset", int'(gateOut), int'(~chanEnable));
    check(!blinkOn, "R1 duty zero after reset", int'(blinkOn), 0);

    // R5: no sync modes keep the pin quiet
    for (int m = 0; m < 2; m++) begin
      syncMode = 2'(m);
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (clkOut || clkOutEn) begin
          check(1'b0, "R5 pin quiet", int'({clkOut, clkOutEn}), 0);
          break;
        end
      end
      check(!clkOut && !clkOutEn, "R5 pin quiet end", int'({clkOut, clkOutEn}), 0);
    end

    // R2 R3 R4: vector table in master mode
    syncMode = 2'b10;
    @(negedge clk);
    check(clkOutEn, "R4 master enable", int'(clkOutEn), 1);
    foreach (VEC[i]) begin
      f = int'(VEC[i][15:8]);
      d = int'(VEC[i][7:0]);
      freqCode = VEC[i][15:8];
      dutyCode = VEC[i][7:0];
      findFall(found);
      check(found, "R4 clock fall seen", int'(found), 1);
      measure(per, on, hi);
      check(per == 256 * (f + 1), "R2 period", per, 256 * (f + 1));
      check(on == d * (f + 1), "R3 on time", on, d * (f + 1));
      check(hi == 128 * (f + 1), "R4 clock high", hi, 128 * (f + 1));
    end

    // R8: per-channel gate with blink open and closed
    freqCode = 8'd0; dutyCode = 8'h80;
    findFall(found);
    @(negedge clk);
    check(blinkOn && gateOut == '1, "R8 gate open", int'(gateOut), int'({NCH{1'b1}}));
    repeat (140) @(negedge clk);
    check(!blinkOn && gateOut == ~chanEnable, "R8 gate closed", int'(gateOut), int'(~chanEnable));

    // R7: change just after a boundary keeps the current period
    freqCode = 8'd1; dutyCode = 8'h80;
    findFall(found);
    freqCode = 8'd3; dutyCode = 8'h10;
    measure(per, on, hi);
    check(per == 512, "R7 old period kept", per, 512);
    check(on == 256, "R7 old duty kept", on, 256);
    measure(per, on, hi);
    check(per == 1024, "R7 new period", per, 1024);
    check(on == 64, "R7 new duty", on, 64);

    // R9: half-rate base tick doubles the period
    freqCode = 8'd0; dutyCode = 8'h40;
    findFall(found);
    halfRate = 1'b1;
    findFall(found);
    measure(per, on, hi);
    check(per == 512, "R9 half rate period", per, 512);
    check(on == 128, "R9 half rate on", on, 128);
    halfRate = 1'b0;

    // R6: slave restart
    findFall(found);
    syncMode = 2'b11;
    dutyCode = 8'h80;
    @(negedge clk);
    check(!clkOut && !clkOutEn, "R6 slave pin", int'({clkOut, clkOutEn}), 0);
    for (int k = 0; k < 300 && blinkOn; k++) @(negedge clk);
    check(!blinkOn, "R6 gate closed before edge", int'(blinkOn), 0);
    clkIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!blinkOn, "R6 no restart before third edge", int'(blinkOn), 0);
    @(negedge clk);
    check(blinkOn, "R6 restart on third edge", int'(blinkOn), 1);
    on = 0;
    for (int k = 0; k < 300 && blinkOn; k++) begin
      on++;
      @(negedge clk);
    end
    check(on == 128, "R6 on time after restart", on, 128);
    clkIn = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule